// File: doc/BRIEF.md
# SDRAM Access Cost Estimator

This block gives a scheduler a number for "how expensive would it be to issue this SDRAM request next". It remembers which row is open in each of four banks, and which bank and column the previous granted access used. For any candidate bank, row and column on its inputs, it reports three things at once. The first is whether the access moves to a different bank. The second is whether it misses the open page of its target bank. The third is how many column address bits would toggle on the shared address lines. It folds these three results into one weighted cost.

The cost is combinational, so an arbiter can present candidates one after another and compare the costs. When a request is granted, the arbiter raises `commit` with that request on the candidate inputs. The state registers then take the request at the next rising clock edge. The three weights sit in small registers that are written through a select/data port. The cost saturates at the top of its 16-bit range.

Top module: `sdram_cost_est`

## Requirements
- R1: After a synchronous active-low reset, no bank has an open row, the remembered bank is 0 and the remembered column is 0. The weights are set to 4 for a bank change, 20 for a page miss and 1 per toggled column bit.
- R2: `bank_change` is 1 exactly when `cand_bank` differs from the remembered bank.
- R3: `page_miss` is 1 when the target bank has no open row, or when its open row differs from `cand_row`.
- R4: `toggle_count` equals the number of bits that differ between `cand_col` and the remembered column.
- R5: `cost` equals bank_change×(bank weight) + page_miss×(page weight) + toggle_count×(bit weight). When that sum exceeds 65535, `cost` is 65535.
- R6: A rising clock edge with `commit` high stores `cand_bank` as the remembered bank and `cand_col` as the remembered column. It also opens `cand_row` in bank `cand_bank`. The outputs follow the candidate inputs with no clock delay.
- R7: Without `commit`, the stored state does not change. A commit to one bank leaves the open rows of the other banks as they were.
- R8: A rising clock edge with `cfg_we` high writes `cfg_wdata` into one weight, chosen by `cfg_sel`: 0 selects the bank weight, 1 the page weight and 2 the bit weight. Select value 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cand_bank | input | 2 | Bank of the candidate request |
| cand_row | input | 13 | Row of the candidate request |
| cand_col | input | 10 | Column of the candidate request |
| commit | input | 1 | Candidate is granted; update state at the edge |
| cfg_we | input | 1 | Weight write enable |
| cfg_sel | input | 2 | Weight select (0 bank, 1 page, 2 bit, 3 none) |
| cfg_wdata | input | 16 | Weight write data |
| bank_change | output | 1 | Candidate bank differs from the remembered bank |
| page_miss | output | 1 | Candidate misses the open row of its bank |
| toggle_count | output | 4 | Column bits that would toggle |
| cost | output | 16 | Saturated weighted cost |

## Verification
Two conditions are hard to reach from the ports. The first is a request that returns to the open row of a bank after a commit to some other bank. The bench reaches it with a committed sequence that moves between banks 0 and 1, then checks bank 1 with no page miss. The second is saturation, which the default weights can never reach. The bench reaches it by programming a large bit weight and presenting a column that toggles all ten bits together with a bank change and a page miss.

// File: rtl/sdram_cost_pkg.sv
// Shared types for the SDRAM access cost estimator.
package sdram_cost_pkg;
    // Selects which weight register a configuration write targets.
    typedef enum logic [1:0] {
        WSEL_BANK = 2'd0,
        WSEL_PAGE = 2'd1,
        WSEL_BIT  = 2'd2,
        WSEL_NONE = 2'd3
    } wsel_e;
endpackage

// File: rtl/sce_open_rows.sv
// Open-row table: one row register and one valid flag per bank.
// Reports a page miss for the candidate and opens the candidate row
// in its bank when commit is high. Assumes banks are numbered 0..NB-1.
module sce_open_rows #(
    parameter int NB     = 4,
    parameter int ROW_W  = 13,
    localparam int BANK_W = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] cand_bank,
    input  logic [ROW_W-1:0]  cand_row,
    input  logic              commit,
    output logic              page_miss
);
    logic [ROW_W-1:0] open_row [NB];
    logic [NB-1:0]    open_vld;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        // Capture the committed row for this bank only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_row[g] <= '0;
                open_vld[g] <= 1'b0;
            end else if (commit && cand_bank == BANK_W'(g)) begin
                open_row[g] <= cand_row;
                open_vld[g] <= 1'b1;
            end
        end

        AST_ROW_OPENED: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && cand_bank == BANK_W'(g)) |=> (open_vld[g] && open_row[g] == $past(cand_row))); // R6
        AST_OTHER_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            !(commit && cand_bank == BANK_W'(g)) |=> ($stable(open_row[g]) && $stable(open_vld[g]))); // R7
    end

    // Compare the candidate row with the open row of its bank.
    always_comb begin
        page_miss = !open_vld[cand_bank] || (open_row[cand_bank] != cand_row);
    end
endmodule

// File: rtl/sce_last_access.sv
// Remembers the bank and column of the last committed request.
module sce_last_access #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [BANK_W-1:0] cand_bank,
    input  logic [COL_W-1:0]  cand_col,
    output logic [BANK_W-1:0] last_bank,
    output logic [COL_W-1:0]  last_col
);
    // Load bank and column on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_bank <= '0;
            last_col  <= '0;
        end else if (commit) begin
            last_bank <= cand_bank;
            last_col  <= cand_col;
        end
    end

    AST_LAST_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (last_bank == $past(cand_bank) && last_col == $past(cand_col))); // R6
    AST_LAST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(last_bank) && $stable(last_col))); // R7
endmodule

// File: rtl/sce_weights.sv
// Weight register file written by select/data. Select value 3 is a no-op.
module sce_weights
    import sdram_cost_pkg::*;
#(
    parameter int          WT_W     = 16,
    parameter logic [15:0] DEF_BANK = 16'd4,
    parameter logic [15:0] DEF_PAGE = 16'd20,
    parameter logic [15:0] DEF_BIT  = 16'd1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  wsel_e           cfg_sel,
    input  logic [WT_W-1:0] cfg_wdata,
    output logic [WT_W-1:0] wt_bank,
    output logic [WT_W-1:0] wt_page,
    output logic [WT_W-1:0] wt_bit
);
    // Write the selected weight; reset to defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wt_bank <= WT_W'(DEF_BANK);
            wt_page <= WT_W'(DEF_PAGE);
            wt_bit  <= WT_W'(DEF_BIT);
        end else if (cfg_we) begin
            case (cfg_sel)
                WSEL_BANK: wt_bank <= cfg_wdata;
                WSEL_PAGE: wt_page <= cfg_wdata;
                WSEL_BIT:  wt_bit  <= cfg_wdata;
                default:   ;
            endcase
        end
    end

    AST_NONE_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == WSEL_NONE) |=> ($stable(wt_bank) && $stable(wt_page) && $stable(wt_bit))); // R8
endmodule

// File: rtl/sce_cost_sum.sv
// Bank compare, column popcount and saturating weighted sum.
// Purely combinational; clk/rst_n only clock the assertions.
module sce_cost_sum #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int WT_W   = 16,
    parameter int COST_W = 16,
    localparam int TGL_W = $clog2(COL_W + 1),
    localparam int SUM_W = WT_W + TGL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] cand_bank,
    input  logic [BANK_W-1:0] last_bank,
    input  logic [COL_W-1:0]  cand_col,
    input  logic [COL_W-1:0]  last_col,
    input  logic              page_miss,
    input  logic [WT_W-1:0]   wt_bank,
    input  logic [WT_W-1:0]   wt_page,
    input  logic [WT_W-1:0]   wt_bit,
    output logic              bank_change,
    output logic [TGL_W-1:0]  toggle_count,
    output logic [COST_W-1:0] cost
);
    localparam logic [SUM_W-1:0] COST_MAX = SUM_W'({COST_W{1'b1}});

    logic [COL_W-1:0] diff;
    logic [SUM_W-1:0] sum;

    // Count the column bits that would toggle.
    always_comb begin
        diff = cand_col ^ last_col;
        toggle_count = '0;
        for (int i = 0; i < COL_W; i++) begin
            toggle_count = toggle_count + TGL_W'(diff[i]);
        end
    end

    // Weighted sum of the three terms, clipped to the output range.
    always_comb begin
        bank_change = (cand_bank != last_bank);
        sum = (bank_change ? SUM_W'(wt_bank) : '0)
            + (page_miss   ? SUM_W'(wt_page) : '0)
            + SUM_W'(wt_bit) * SUM_W'(toggle_count);
        cost = (sum > COST_MAX) ? {COST_W{1'b1}} : sum[COST_W-1:0];
    end

    AST_TOGGLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_count <= TGL_W'(COL_W)); // R4
    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_change && !page_miss && toggle_count == '0) |-> cost == '0); // R5
    AST_PAGE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        page_miss |-> ({{(SUM_W-COST_W){1'b0}}, cost} >= SUM_W'(wt_page)
                       || cost == {COST_W{1'b1}})); // R5
endmodule

// File: rtl/sdram_cost_est.sv
// Top: SDRAM access cost estimator. Combinational cost for the
// candidate request; the state registers follow committed requests.
module sdram_cost_est
    import sdram_cost_pkg::*;
#(
    parameter int NB     = 4,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int WT_W   = 16,
    parameter int COST_W = 16,
    localparam int BANK_W = $clog2(NB),
    localparam int TGL_W  = $clog2(COL_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] cand_bank,
    input  logic [ROW_W-1:0]  cand_row,
    input  logic [COL_W-1:0]  cand_col,
    input  logic              commit,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [WT_W-1:0]   cfg_wdata,
    output logic              bank_change,
    output logic              page_miss,
    output logic [TGL_W-1:0]  toggle_count,
    output logic [COST_W-1:0] cost
);
    logic [BANK_W-1:0] last_bank;
    logic [COL_W-1:0]  last_col;
    logic [WT_W-1:0]   wt_bank, wt_page, wt_bit;

    sce_open_rows #(.NB(NB), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .cand_bank(cand_bank), .cand_row(cand_row),
        .commit(commit), .page_miss(page_miss)
    );

    sce_last_access #(.BANK_W(BANK_W), .COL_W(COL_W)) u_last (
        .clk(clk), .rst_n(rst_n), .commit(commit), .cand_bank(cand_bank),
        .cand_col(cand_col), .last_bank(last_bank), .last_col(last_col)
    );

    sce_weights #(.WT_W(WT_W)) u_wts (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(wsel_e'(cfg_sel)),
        .cfg_wdata(cfg_wdata), .wt_bank(wt_bank), .wt_page(wt_page), .wt_bit(wt_bit)
    );

    sce_cost_sum #(.BANK_W(BANK_W), .COL_W(COL_W), .WT_W(WT_W), .COST_W(COST_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .cand_bank(cand_bank), .last_bank(last_bank),
        .cand_col(cand_col), .last_col(last_col), .page_miss(page_miss),
        .wt_bank(wt_bank), .wt_page(wt_page), .wt_bit(wt_bit),
        .bank_change(bank_change), .toggle_count(toggle_count), .cost(cost)
    );

    AST_BANK_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (cand_bank != $past(cand_bank) || !bank_change)); // R2
endmodule

// File: tb/sdram_cost_est_tb.sv
module sdram_cost_est_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cand_bank = '0;
    logic [12:0] cand_row = '0;
    logic [9:0]  cand_col = '0;
    logic        commit = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        bank_change, page_miss;
    logic [3:0]  toggle_count;
    logic [15:0] cost;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cost_est u_dut (
        .clk(clk), .rst_n(rst_n), .cand_bank(cand_bank), .cand_row(cand_row),
        .cand_col(cand_col), .commit(commit), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bank_change(bank_change), .page_miss(page_miss),
        .toggle_count(toggle_count), .cost(cost)
    );

    typedef struct packed {
        logic [1:0]  bank;
        logic [12:0] row;
        logic [9:0]  col;
        logic        cmt;
        logic        bc;
        logic        pm;
        logic [3:0]  tog;
        logic [15:0] cost;
    } vec_t;

    // Weights 4/20/1. State carried from one row to the next.
    localparam vec_t VECS [9] = '{
        '{2'd0, 13'd5, 10'h000, 1'b1, 1'b0, 1'b1, 4'd0,  16'd20},
        '{2'd0, 13'd5, 10'h00F, 1'b1, 1'b0, 1'b0, 4'd4,  16'd4},
        '{2'd1, 13'd7, 10'h00F, 1'b1, 1'b1, 1'b1, 4'd0,  16'd24},
        '{2'd0, 13'd5, 10'h0F0, 1'b0, 1'b1, 1'b0, 4'd8,  16'd12},
        '{2'd0, 13'd6, 10'h00F, 1'b1, 1'b1, 1'b1, 4'd0,  16'd24},
        '{2'd1, 13'd7, 10'h3F0, 1'b1, 1'b1, 1'b0, 4'd10, 16'd14},
        '{2'd3, 13'd0, 10'h3F0, 1'b0, 1'b1, 1'b1, 4'd0,  16'd24},
        '{2'd0, 13'd6, 10'h3F1, 1'b1, 1'b1, 1'b0, 4'd1,  16'd5},
        '{2'd0, 13'd6, 10'h3F1, 1'b0, 1'b0, 1'b0, 4'd0,  16'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a candidate at the falling edge and sample 1 time unit later.
    task automatic present(input logic [1:0] b, input logic [12:0] r,
                           input logic [9:0] c, input logic cm);
        @(negedge clk);
        cand_bank = b; cand_row = r; cand_col = c; commit = cm;
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        commit = 1'b0; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen through the ports
        present(2'd0, 13'd0, 10'h000, 1'b0);
        check("R1 bank_change", bank_change, 0);
        check("R1 page_miss", page_miss, 1);
        check("R1 cost", cost, 20);
        present(2'd2, 13'd0, 10'h001, 1'b0);
        check("R1 default weights cost", cost, 25);

        // Vector walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 9; i++) begin
            present(VECS[i].bank, VECS[i].row, VECS[i].col, VECS[i].cmt);
            check("R2 bank_change", bank_change, VECS[i].bc);
            check("R3 page_miss", page_miss, VECS[i].pm);
            check("R4 toggle_count", toggle_count, VECS[i].tog);
            check("R5 cost", cost, VECS[i].cost);
        end

        // R7: bank 1 row 7 still open after commits to bank 0
        present(2'd1, 13'd7, 10'h3F1, 1'b0);
        check("R7 other bank row kept", page_miss, 0);
        check("R7 bank change vs last bank 0", bank_change, 1);

        // R5 saturation: bit weight 8192, 10 toggles, bank change and page miss
        cfg_write(2'd2, 16'd8192);
        present(2'd2, 13'd1, 10'h00E, 1'b0);
        check("R5 toggle all bits", toggle_count, 10);
        check("R5 saturated cost", cost, 65535);

        // R8: select 3 changes no weight
        cfg_write(2'd2, 16'd1);
        cfg_write(2'd3, 16'hFFFF);
        present(2'd2, 13'd1, 10'h00E, 1'b0);
        check("R8 select 3 ignored", cost, 34);
        cfg_write(2'd0, 16'd100);
        present(2'd2, 13'd1, 10'h00E, 1'b0);
        check("R8 bank weight write", cost, 130);
        cfg_write(2'd1, 16'd0);
        present(2'd2, 13'd1, 10'h00E, 1'b0);
        check("R8 page weight write", cost, 110);

        // R6: outputs follow inputs with no clock delay
        present(2'd0, 13'd6, 10'h3F1, 1'b0);
        check("R6 combinational cost", cost, 0);

        // R1: reset again restores state and weights
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        present(2'd0, 13'd6, 10'h000, 1'b0);
        check("R1 rows cleared", page_miss, 1);
        check("R1 weights restored", cost, 20);

        finish_run();
    end
endmodule